// File: doc/BRIEF.md
# Counter-Instruction Stored-Program Core

This block is a minimal von Neumann processor. Code and data occupy one word-addressed memory, and the program language has four operations: stop, add one to a memory cell, subtract one from a memory cell, and branch when a memory cell is zero. Because an instruction is just words in the same memory it works on, a program can rewrite its own opcodes and operands while it runs.

A host fills the memory through a simple port while the core is idle. It then pulses a start input with an entry address. The core walks the program one instruction at a time. Each instruction passes through a fixed state sequence: opcode fetch, decode, operand fetch, target read, and then either a write-back or a branch-target fetch. The core stops on a zero opcode or on an unknown one, and it reports which of the two occurred. The host can then read back the results.

Top module: `cnt_core`

## Requirements
- R1: After reset the core is idle: `busy_o`, `halted_o` and `illegal_o` are 0 and `pc_o` is 0.
- R2: A `start_i` pulse while idle loads `pc_o` from `start_addr_i`, clears both status flags and raises `busy_o` on the next cycle. A `start_i` pulse while busy has no effect on the running program.
- R3: Opcode word 1 is a two-word increment: it adds one to mem[r], wrapping 0xFFFF to 0, and execution continues at the address two words past the opcode.
- R4: Opcode word 2 is a two-word decrement: it subtracts one from mem[r], except that a cell holding 0 stays 0, and execution continues two words past the opcode.
- R5: Opcode word 3 is a three-word jump-if-zero with operands r and z. When mem[r] is 0 the next fetch is from z. Otherwise it is from three words past the opcode. Memory is not written.
- R6: Opcode word 0 stops the core with `halted_o` = 1 and `busy_o` = 0, and `pc_o` holds the address of that halt word.
- R7: Any opcode word above 3, including words with upper bits set, stops the core with `illegal_o` = 1, `halted_o` = 0, and `pc_o` at the offending word. Memory is left unchanged.
- R8: An operand word names a memory address through its low 8 bits only. Instructions are fetched in ascending address order unless a jump is taken. A cell written by the program is seen by any later fetch, so self-modifying code works.
- R9: While idle, `host_we_i` writes `host_wdata_i` to mem[`host_addr_i`], and `host_rdata_o` shows mem[`host_addr_i`] one cycle after the address is presented. While busy, host writes are ignored.
- R10: The program 3,18,15, 2,18, 1,19, 3,15,5 placed at address 5, with 0 at address 15, moves the value n from cell 18 into cell 19, leaves cell 18 at 0, and halts with `pc_o` = 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_addr_i | input | 8 | Entry address loaded into the program counter on start |
| host_we_i | input | 1 | Host write enable, effective only while idle |
| host_addr_i | input | 8 | Host read/write address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Memory word at the host address, one cycle later |
| busy_o | output | 1 | Core is executing a program |
| halted_o | output | 1 | Core stopped on a halt opcode |
| illegal_o | output | 1 | Core stopped on an undefined opcode |
| pc_o | output | 8 | Program counter |

## Verification
Faults in the state sequence show up at the ports in a few ways. A slip in program-counter arithmetic or in operand latching makes the core stop at the wrong `pc_o`, raise the wrong flag, or leave a cell with the wrong value. All of these can be seen at the moment `busy_o` falls, a handful of cycles into a one-instruction program. A fault in arbitration shows up as a host-written cell, or a restarted program, after the next idle readback. Counting errors that build up over many iterations, such as a misread branch condition, appear only when the transfer program finishes, so a longer transfer run is included.

// File: rtl/cnt_core_pkg.sv
package cnt_core_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_OP,
    S_DECODE,
    S_FETCH_OPND,
    S_READ_TARGET,
    S_WRITE_BACK,
    S_BRANCH
  } state_e;

  typedef enum logic [1:0] {
    OP_HALT = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_JZ   = 2'd3
  } op_e;

endpackage

// File: rtl/cnt_mem.sv
module cnt_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  // single port, registered read: data valid one cycle after address
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/cnt_alu.sv
module cnt_alu #(
  parameter int DW = 16
) (
  input  logic          dec_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] res_o
);
  localparam logic [DW-1:0] One = DW'(1);

  always_comb begin
    if (dec_i) res_o = (val_i == '0) ? '0 : val_i - One;  // floor at zero
    else       res_o = val_i + One;                       // wraps
  end
endmodule

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_core_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          busy_o,
  output logic          halted_o,
  output logic          illegal_o,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] Step1 = AW'(1);
  localparam logic [AW-1:0] Step2 = AW'(2);
  localparam logic [AW-1:0] Step3 = AW'(3);

  state_e        state_q, state_d;
  op_e           op_q, op_d;
  logic [AW-1:0] pc_q, pc_d, r_q, r_d;
  logic [DW-1:0] tgt_q, tgt_d, alu_res;
  logic          halted_q, halted_d, illegal_q, illegal_d;

  cnt_alu #(.DW(DW)) i_alu (
    .dec_i (op_q == OP_DEC),
    .val_i (tgt_q),
    .res_o (alu_res)
  );

  always_comb begin
    state_d     = state_q;
    op_d        = op_q;
    pc_d        = pc_q;
    r_d         = r_q;
    tgt_d       = tgt_q;
    halted_d    = halted_q;
    illegal_d   = illegal_q;
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = alu_res;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          pc_d      = start_addr_i;
          halted_d  = 1'b0;
          illegal_d = 1'b0;
          state_d   = S_FETCH_OP;
        end
      end
      S_FETCH_OP: begin
        mem_addr_o = pc_q;
        state_d    = S_DECODE;
      end
      S_DECODE: begin
        mem_addr_o = pc_q + Step1;
        if (|rdata_i[DW-1:2]) begin
          illegal_d = 1'b1;
          state_d   = S_IDLE;
        end else if (rdata_i[1:0] == OP_HALT) begin
          halted_d = 1'b1;
          state_d  = S_IDLE;
        end else begin
          op_d    = op_e'(rdata_i[1:0]);
          state_d = S_FETCH_OPND;
        end
      end
      S_FETCH_OPND: begin
        r_d        = rdata_i[AW-1:0];
        mem_addr_o = rdata_i[AW-1:0];
        state_d    = S_READ_TARGET;
      end
      S_READ_TARGET: begin
        tgt_d = rdata_i;
        if (op_q == OP_JZ) begin
          if (rdata_i == '0) begin
            mem_addr_o = pc_q + Step2;
            state_d    = S_BRANCH;
          end else begin
            pc_d    = pc_q + Step3;
            state_d = S_FETCH_OP;
          end
        end else begin
          state_d = S_WRITE_BACK;
        end
      end
      S_WRITE_BACK: begin
        mem_addr_o = r_q;
        mem_we_o   = 1'b1;
        pc_d       = pc_q + Step2;
        state_d    = S_FETCH_OP;
      end
      S_BRANCH: begin
        pc_d    = rdata_i[AW-1:0];
        state_d = S_FETCH_OP;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= OP_HALT;
      pc_q      <= '0;
      r_q       <= '0;
      tgt_q     <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      pc_q      <= pc_d;
      r_q       <= r_d;
      tgt_q     <= tgt_d;
      halted_q  <= halted_d;
      illegal_q <= illegal_d;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign halted_o  = halted_q;
  assign illegal_o = illegal_q;
  assign pc_o      = pc_q;

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && pc_o == $past(start_addr_i)));

  // R6
  halt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || illegal_o) |-> !busy_o);

  // R7
  one_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halted_o && illegal_o));

  // R6
  halt_pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> $stable(pc_o));

  // R3
  wb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WRITE_BACK) |=> (pc_o == $past(pc_o) + Step2));

  // R4
  dec_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && op_q == OP_DEC) |-> (mem_wdata_o + DW'(tgt_q != '0)) == tgt_q);

  // R5
  branch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRANCH) |=> (pc_o == $past(rdata_i[AW-1:0])));
endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          busy_o,
  output logic          halted_o,
  output logic          illegal_o,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] core_addr, mem_addr;
  logic          core_we, mem_we;
  logic [DW-1:0] core_wdata, mem_wdata, mem_rdata;

  cnt_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .rdata_i      (mem_rdata),
    .mem_addr_o   (core_addr),
    .mem_we_o     (core_we),
    .mem_wdata_o  (core_wdata),
    .busy_o       (busy_o),
    .halted_o     (halted_o),
    .illegal_o    (illegal_o),
    .pc_o         (pc_o)
  );

  // core owns the memory while running; host only when idle
  assign mem_addr  = busy_o ? core_addr  : host_addr_i;
  assign mem_we    = busy_o ? core_we    : host_we_i;
  assign mem_wdata = busy_o ? core_wdata : host_wdata_i;

  cnt_mem #(.AW(AW), .DW(DW)) i_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  assign host_rdata_o = mem_rdata;

  // R9
  host_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !core_we) |-> !mem_we);
endmodule

// File: tb/test_cnt_core.sv
`timescale 1ns/1ps
module test_cnt_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  start_addr_i = '0;
  logic        host_we_i = 1'b0;
  logic [7:0]  host_addr_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic        busy_o, halted_o, illegal_o;
  logic [7:0]  pc_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cnt_core i_cnt_core (
    .clk_i, .rst_ni, .start_i, .start_addr_i, .host_we_i, .host_addr_i,
    .host_wdata_i, .host_rdata_o, .busy_o, .halted_o, .illegal_o, .pc_o
  );

  // {opcode, initial mem[0x80], expected mem[0x80], expected pc, expected illegal}
  localparam logic [63:0] VEC [10] = '{
    {16'h0001, 16'h0005, 16'h0006, 8'h22, 8'h00},
    {16'h0001, 16'hFFFF, 16'h0000, 8'h22, 8'h00},
    {16'h0002, 16'h0005, 16'h0004, 8'h22, 8'h00},
    {16'h0002, 16'h0000, 16'h0000, 8'h22, 8'h00},
    {16'h0003, 16'h0000, 16'h0000, 8'h30, 8'h00},
    {16'h0003, 16'h0007, 16'h0007, 8'h23, 8'h00},
    {16'h0000, 16'h0009, 16'h0009, 8'h20, 8'h00},
    {16'h0004, 16'h0003, 16'h0003, 8'h20, 8'h01},
    {16'h0101, 16'h0003, 16'h0003, 8'h20, 8'h01},
    {16'hFFFF, 16'h0011, 16'h0011, 8'h20, 8'h01}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    host_addr_i = a; host_wdata_i = d; host_we_i = 1'b1;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk_i);
    host_addr_i = a;
    @(negedge clk_i);
    d = host_rdata_o;
  endtask

  task automatic pulse_start(input logic [7:0] a);
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy_o && k < 20000) begin
      @(negedge clk_i);
      k++;
    end
    if (busy_o) chk(req, "core did not stop", 32'd1, 32'd0);
  endtask

  task automatic load_move(input logic [15:0] n);
    host_wr(8'd5, 16'd3);  host_wr(8'd6, 16'd18); host_wr(8'd7, 16'd15);
    host_wr(8'd8, 16'd2);  host_wr(8'd9, 16'd18);
    host_wr(8'd10, 16'd1); host_wr(8'd11, 16'd19);
    host_wr(8'd12, 16'd3); host_wr(8'd13, 16'd15); host_wr(8'd14, 16'd5);
    host_wr(8'd15, 16'd0);
    host_wr(8'd18, n);     host_wr(8'd19, 16'd0);
  endtask

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1", "busy", 32'(busy_o), 0);
    chk("R1", "halted", 32'(halted_o), 0);
    chk("R1", "illegal", 32'(illegal_o), 0);
    chk("R1", "pc", 32'(pc_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1", "idle after release", 32'(busy_o), 0);

    // R9 host write/read while idle
    host_wr(8'hA5, 16'h5A3C);
    host_rd(8'hA5, rd);
    chk("R9", "host readback", 32'(rd), 32'h5A3C);

    // table of single-instruction programs at 0x20
    for (int i = 0; i < 10; i++) begin
      logic [15:0] op, init, expv;
      logic [7:0]  exppc, expil;
      string req;
      {op, init, expv, exppc, expil} = VEC[i];
      case (op)
        16'd1: req = "R3";
        16'd2: req = "R4";
        16'd3: req = "R5";
        16'd0: req = "R6";
        default: req = "R7";
      endcase
      host_wr(8'h20, op);
      host_wr(8'h21, 16'h0080);
      host_wr(8'h22, (op == 16'd3) ? 16'h0030 : 16'h0000);
      host_wr(8'h23, 16'h0000);
      host_wr(8'h30, 16'h0000);
      host_wr(8'h80, init);
      pulse_start(8'h20);
      // R2
      chk("R2", "busy after start", 32'(busy_o || halted_o || illegal_o), 1);
      wait_idle(req);
      chk(req, "pc at stop", 32'(pc_o), 32'(exppc));
      chk(req, "illegal flag", 32'(illegal_o), 32'(expil));
      chk(req, "halted flag", 32'(halted_o), 32'(expil == 8'h00));
      host_rd(8'h80, rd);
      chk(req, "target cell", 32'(rd), 32'(expv));
    end

    // R10 transfer program
    load_move(16'd4);
    pulse_start(8'd5);
    wait_idle("R10");
    chk("R10", "pc", 32'(pc_o), 15);
    chk("R10", "halted", 32'(halted_o), 1);
    host_rd(8'd18, rd);
    chk("R10", "source cell", 32'(rd), 0);
    host_rd(8'd19, rd);
    chk("R10", "destination cell", 32'(rd), 4);

    // R8 self-modifying code with high operand bits set
    host_wr(8'h40, 16'h0001); host_wr(8'h41, 16'hFF42);
    host_wr(8'h42, 16'h0000); host_wr(8'h43, 16'hAB50);
    host_wr(8'h44, 16'h0000); host_wr(8'h50, 16'h0007);
    pulse_start(8'h40);
    wait_idle("R8");
    chk("R8", "pc after rewritten code", 32'(pc_o), 32'h44);
    host_rd(8'h42, rd);
    chk("R8", "rewritten opcode", 32'(rd), 1);
    host_rd(8'h50, rd);
    chk("R8", "cell touched by new code", 32'(rd), 8);

    // R2 / R9: start and host writes ignored while busy
    host_wr(8'h90, 16'h1234);
    load_move(16'd40);
    pulse_start(8'd5);
    repeat (3) @(negedge clk_i);
    host_addr_i = 8'h90; host_wdata_i = 16'hBEEF; host_we_i = 1'b1;
    start_i = 1'b1; start_addr_i = 8'h20;
    @(negedge clk_i);
    host_we_i = 1'b0; start_i = 1'b0;
    wait_idle("R2");
    chk("R2", "restart ignored, pc", 32'(pc_o), 15);
    host_rd(8'd19, rd);
    chk("R2", "run completed", 32'(rd), 40);
    host_rd(8'h90, rd);
    chk("R9", "busy host write dropped", 32'(rd), 32'h1234);

    // R6 halt pc stays put while idle
    repeat (5) @(negedge clk_i);
    chk("R6", "pc held while halted", 32'(pc_o), 15);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule